// File: doc/BRIEF.md
# Parallel Top-Two Track Sorter

This block takes up to twelve candidate track words in each bunch crossing and forwards the two best of them, ranked by quality and then by transverse momentum. The twelve slots are fed as pairs by six neighbouring track-finder sources. Slot `2s` and slot `2s+1` belong to source `s`. Duplicate removal upstream clears a track it judges a ghost by zeroing its rank, so a cleared track arrives as an empty candidate.

Each candidate is compared against all eleven others in a single combinational network. The number of candidates that beat a given one is its position. The candidates at positions 0 and 1 steer one-hot multiplexers that carry their complete 31-bit words to the two output slots. One register stage captures the inputs and a second captures the outputs, so the latency is fixed at two clock periods and a new set of candidates can be accepted every cycle.

Top module: `top2_track_sorter`

## Requirements
- R1: The outputs present the result for the candidate set that was on `inWords` at the rising edge two edges earlier. A set that was sampled only one edge earlier has not yet reached the outputs.
- R2: Output slot 0 carries the candidate with the highest rank among all non-empty candidates.
- R3: Output slot 1 carries the non-empty candidate with the second highest rank. Slot 1 is never valid while slot 0 is empty.
- R4: The rank is bits [30:23] of a track word. Quality sits in bits [30:28] and momentum in bits [27:23], so a higher quality always beats a higher momentum.
- R5: When two candidates have equal ranks, the candidate with the lower slot index wins. Equal candidates can therefore fill both outputs.
- R6: A candidate whose rank is zero is empty and is never selected, whatever its other bits hold.
- R7: An output slot that has no candidate drives an all-zero word and holds its valid bit low.
- R8: A selected candidate's 31-bit word appears on its output slot bit for bit. Slot `k` occupies `outWords[k*31 +: 31]` and input slot `i` occupies `inWords[i*31 +: 31]`.
- R9: While `rstN` is low, both output words are zero and both valid bits are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inWords | input | 372 | Twelve candidate track words, slot i at bits [i*31 +: 31] |
| outWords | output | 62 | Two winning track words, slot k at bits [k*31 +: 31] |
| outValid | output | 2 | Per-slot flag, high when the slot holds a candidate |

## Verification
The bench targets the following corner cases:
- A quality-4, momentum-0 track set against a quality-3, momentum-31 track. A design that compared momentum first, or that took the wrong bit slice, would swap the winners.
- Three-way and twelve-way rank ties. Logic that broke ties the wrong way round, or not at all, would output the wrong slots, or output one candidate twice and leave a slot empty.
- Empty candidates that still carry non-zero payload bits, including sets with zero or one non-empty candidate. These show whether an empty candidate can leak through, and whether an empty slot really drives zeros with its valid bit low.
- Sets that change on back-to-back cycles, and a reset applied while data is present. These expose a pipeline that is one stage short or long, or one that does not clear.

// File: rtl/top2_sort_pkg.sv
package top2_sort_pkg;
  // counts fixed at package level so the strobe struct has a static shape
  localparam int NUM_IN  = 12;
  localparam int NUM_OUT = 2;
  localparam int WORD_W  = 31;
  localparam int QUAL_W  = 3;
  localparam int PT_W    = 5;
  localparam int RANK_W  = QUAL_W + PT_W;
  localparam int RANK_LSB = WORD_W - RANK_W;
  localparam int POS_W   = $clog2(NUM_IN);

  // strobes from the comparison network to the datapath
  typedef struct packed {
    logic [NUM_OUT-1:0][NUM_IN-1:0] pick;  // one-hot source per output slot
    logic [NUM_OUT-1:0]             fill;  // output slot has a winner
  } selStrobes_t;
endpackage

// File: rtl/tts_rank_ctrl.sv
module tts_rank_ctrl
  import top2_sort_pkg::*;
#(
  parameter int RANK_BITS = RANK_W
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic [NUM_IN-1:0][RANK_BITS-1:0]    stageRanks,
  output selStrobes_t                         strobes
);
  // beatenBy[i][j]: candidate j outranks candidate i
  logic [NUM_IN-1:0][NUM_IN-1:0] beatenBy;
  logic [NUM_IN-1:0][POS_W-1:0]  position;
  logic [NUM_IN-1:0]             nonEmpty;

  genvar gi, gj, gk;
  generate
    for (gi = 0; gi < NUM_IN; gi++) begin : g_row
      assign nonEmpty[gi] = |stageRanks[gi];
      for (gj = 0; gj < NUM_IN; gj++) begin : g_col
        if (gj == gi) begin : g_self
          assign beatenBy[gi][gj] = 1'b0;
        end else if (gj < gi) begin : g_lower
          // lower index wins on an equal rank
          assign beatenBy[gi][gj] = (stageRanks[gj] >= stageRanks[gi]);
        end else begin : g_upper
          assign beatenBy[gi][gj] = (stageRanks[gj] > stageRanks[gi]);
        end
      end
    end
  endgenerate

  always_comb begin
    for (int i = 0; i < NUM_IN; i++) begin
      position[i] = '0;
      for (int j = 0; j < NUM_IN; j++) begin
        position[i] = position[i] + POS_W'(beatenBy[i][j]);
      end
    end
  end

  generate
    for (gk = 0; gk < NUM_OUT; gk++) begin : g_slot
      for (gi = 0; gi < NUM_IN; gi++) begin : g_cand
        assign strobes.pick[gk][gi] = nonEmpty[gi] && (position[gi] == POS_W'(gk));
      end
      assign strobes.fill[gk] = |strobes.pick[gk];

      // R5
      pick_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
        $onehot0(strobes.pick[gk]));
    end
  endgenerate

  // R3
  fill_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.fill[1] |-> strobes.fill[0]);

  // R2
  distinct_pick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.pick[0] & strobes.pick[1]) == '0);
endmodule

// File: rtl/tts_datapath.sv
module tts_datapath
  import top2_sort_pkg::*;
#(
  parameter int WORD_BITS = WORD_W,
  parameter int RANK_BITS = RANK_W,
  localparam int RANK_LO  = WORD_BITS - RANK_BITS
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic [NUM_IN*WORD_BITS-1:0]         inWords,
  input  selStrobes_t                         strobes,
  output logic [NUM_IN-1:0][RANK_BITS-1:0]    stageRanks,
  output logic [NUM_OUT*WORD_BITS-1:0]        outWords,
  output logic [NUM_OUT-1:0]                  outValid
);
  logic [NUM_IN-1:0][WORD_BITS-1:0]  stageWord;
  logic [NUM_OUT-1:0][WORD_BITS-1:0] muxWord;
  logic [NUM_OUT-1:0][WORD_BITS-1:0] outWordReg;
  logic                              stageAny;

  // first pipeline stage: capture every candidate
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageWord <= '0;
    end else begin
      for (int i = 0; i < NUM_IN; i++) begin
        stageWord[i] <= inWords[i*WORD_BITS +: WORD_BITS];
      end
    end
  end

  genvar gi, gk;
  generate
    for (gi = 0; gi < NUM_IN; gi++) begin : g_rank
      assign stageRanks[gi] = stageWord[gi][WORD_BITS-1:RANK_LO];
    end
  endgenerate

  assign stageAny = |stageRanks;

  // one-hot AND-OR multiplexers
  always_comb begin
    for (int k = 0; k < NUM_OUT; k++) begin
      muxWord[k] = '0;
      for (int i = 0; i < NUM_IN; i++) begin
        muxWord[k] = muxWord[k] | (stageWord[i] & {WORD_BITS{strobes.pick[k][i]}});
      end
    end
  end

  // second pipeline stage: registered outputs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outWordReg <= '0;
      outValid   <= '0;
    end else begin
      outWordReg <= muxWord;
      outValid   <= strobes.fill;
    end
  end

  generate
    for (gk = 0; gk < NUM_OUT; gk++) begin : g_out
      assign outWords[gk*WORD_BITS +: WORD_BITS] = outWordReg[gk];

      // R7
      empty_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
        !outValid[gk] |-> (outWordReg[gk] == '0));

      // R6
      valid_rank_chk: assert property (@(posedge clk) disable iff (!rstN)
        outValid[gk] |-> (outWordReg[gk][WORD_BITS-1:RANK_LO] != '0));
    end
  endgenerate

  // R2
  rank_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid[1] |-> (outWordReg[0][WORD_BITS-1:RANK_LO] >= outWordReg[1][WORD_BITS-1:RANK_LO]));

  // R1
  latency_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    stageAny |=> outValid[0]);

  // R1
  latency_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stageAny |=> !outValid[0]);
endmodule

// File: rtl/top2_track_sorter.sv
module top2_track_sorter
  import top2_sort_pkg::*;
#(
  parameter int WORD_BITS = WORD_W,
  parameter int RANK_BITS = RANK_W
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_IN*WORD_BITS-1:0]   inWords,
  output logic [NUM_OUT*WORD_BITS-1:0]  outWords,
  output logic [NUM_OUT-1:0]            outValid
);
  logic [NUM_IN-1:0][RANK_BITS-1:0] stageRanks;
  selStrobes_t                      strobes;

  tts_datapath #(
    .WORD_BITS(WORD_BITS),
    .RANK_BITS(RANK_BITS)
  ) u_datapath (
    .clk(clk),
    .rstN(rstN),
    .inWords(inWords),
    .strobes(strobes),
    .stageRanks(stageRanks),
    .outWords(outWords),
    .outValid(outValid)
  );

  tts_rank_ctrl #(
    .RANK_BITS(RANK_BITS)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .stageRanks(stageRanks),
    .strobes(strobes)
  );
endmodule

// File: tb/top2_track_sorter_tb.sv
module top2_track_sorter_tb;
  localparam int NI = 12;
  localparam int NO = 2;
  localparam int WW = 31;
  localparam int NV = 9;
  localparam int NONE = 15;

  // rank per input slot, index 0..11
  localparam logic [7:0] VEC_RANK [NV][NI] = '{
    '{8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00},
    '{8'h00,8'h00,8'h00,8'h00,8'h00,8'h40,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00},
    '{8'h00,8'h00,8'h00,8'h21,8'h00,8'h00,8'h00,8'h80,8'h00,8'h00,8'h7F,8'h00},
    '{8'h00,8'h00,8'h55,8'h00,8'h55,8'h00,8'h00,8'h00,8'h00,8'h55,8'h00,8'h00},
    '{8'hFF,8'hFF,8'hFF,8'hFF,8'hFF,8'hFF,8'hFF,8'hFF,8'hFF,8'hFF,8'hFF,8'hFF},
    '{8'h01,8'h02,8'h03,8'h04,8'h05,8'h06,8'h07,8'h08,8'h09,8'h0A,8'h0B,8'h0C},
    '{8'h01,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h02},
    '{8'h00,8'hE3,8'h00,8'h00,8'h00,8'h00,8'hE4,8'h00,8'hE4,8'h00,8'h00,8'h00},
    '{8'h00,8'h00,8'h00,8'h21,8'h3F,8'h40,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00}
  };
  // expected winning slot index per output, NONE when empty
  localparam int VEC_EXP [NV][NO] = '{
    '{NONE, NONE}, '{5, NONE}, '{7, 10}, '{2, 4}, '{0, 1},
    '{11, 10}, '{11, 0}, '{6, 8}, '{5, 4}
  };
  localparam string VEC_TAG [NV] = '{
    "R6 all empty", "R7 single candidate", "R4 quality dominates",
    "R5 three-way tie", "R5 full tie", "R2 ascending ranks",
    "R3 minimal ranks", "R5 tie above", "R4 momentum order"
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [NI*WW-1:0]  inWords = '0;
  logic [NO*WW-1:0]  outWords;
  logic [NO-1:0]     outValid;
  int                nChecks = 0;
  int                nFails = 0;
  bit                finished = 1'b0;

  always #5 clk = ~clk;

  top2_track_sorter u_dut (
    .clk(clk),
    .rstN(rstN),
    .inWords(inWords),
    .outWords(outWords),
    .outValid(outValid)
  );

  // R8: payload bits are distinct per vector and slot, non-zero even for empty candidates
  function automatic logic [WW-1:0] mkWord(int v, int i);
    logic [22:0] payload;
    payload = 23'(v * 4099 + i * 131 + 'h2A5);
    return {VEC_RANK[v][i], payload};
  endfunction

  task automatic driveVec(int v);
    for (int i = 0; i < NI; i++) inWords[i*WW +: WW] = mkWord(v, i);
  endtask

  task automatic checkSlot(int k, int v, int expIdx, string tag);
    logic [WW-1:0] expWord;
    logic          expValid;
    expWord  = (expIdx == NONE) ? '0 : mkWord(v, expIdx);
    expValid = (expIdx != NONE);
    nChecks++;
    if (outWords[k*WW +: WW] !== expWord || outValid[k] !== expValid) begin
      nFails++;
      $display("FAIL %s slot %0d: got word %h valid %b, expected word %h valid %b",
               tag, k, outWords[k*WW +: WW], outValid[k], expWord, expValid);
    end
  endtask

  task automatic checkVec(int v, string tag);
    for (int k = 0; k < NO; k++) checkSlot(k, v, VEC_EXP[v][k], tag);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    // R9: reset state
    driveVec(4);
    repeat (3) @(posedge clk);
    #2;
    checkSlot(0, 0, NONE, "R9 reset");
    checkSlot(1, 0, NONE, "R9 reset");
    @(negedge clk);
    rstN = 1'b1;

    // table walk (R2 R3 R4 R5 R6 R7 R8)
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      driveVec(v);
      @(posedge clk);
      @(posedge clk);
      #2;
      checkVec(v, VEC_TAG[v]);
    end

    // R1: back-to-back sets, exact two-edge latency
    @(negedge clk);
    driveVec(2);
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    driveVec(3);
    @(posedge clk);
    #2;
    checkVec(2, "R1 one edge later");
    @(posedge clk);
    #2;
    checkVec(3, "R1 two edges later");
    @(negedge clk);
    driveVec(0);
    @(posedge clk);
    #2;
    checkVec(3, "R1 hold before empty");
    @(posedge clk);
    #2;
    checkVec(0, "R1 empty arrives");

    // R9: asynchronous reset while data is present
    @(negedge clk);
    driveVec(4);
    @(posedge clk);
    @(posedge clk);
    #2;
    checkVec(4, "R1 before reset");
    @(negedge clk);
    rstN = 1'b0;
    #2;
    checkSlot(0, 0, NONE, "R9 mid-run reset");
    checkSlot(1, 0, NONE, "R9 mid-run reset");
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #2;
    checkSlot(0, 0, NONE, "R1 first edge after reset");
    @(posedge clk);
    #2;
    checkVec(4, "R1 recovery after reset");

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule